// File: doc/BRIEF.md
# Four-Instruction Load/Store Core

This block is a single-cycle 32-bit processor that executes a minimal instruction set: register add, register subtract, word load and word store. Each clock cycle it fetches one 32-bit word from an internal instruction memory at the program counter. It decodes the word, reads two operands from a 32-entry register file and computes a result in the arithmetic unit. The result is either an arithmetic value or an effective address. It then commits either a register write or a data-memory write.

Both memories are small internal word arrays. While reset is held, a loader port fills them. Once reset is released, the loader is inert and the program counter steps through instruction memory word by word. A debug bus shows every architectural side effect of the current instruction: the program counter, the register write strobe, address and data, and the memory write strobe, address and data. A cycle-by-cycle reference model can compare against it.

Top module: `core4_top`

## Requirements
- R1: The program counter is 0 out of reset and grows by 4 on every clock edge after reset. Instruction memory is indexed by program-counter bits [MEM_AW+1:2], so fetch wraps over the memory depth.
- R2: An instruction with op field bits [31:26] = 0 and funct bits [5:0] = 32 writes rs + rt into rd, wrapping modulo 2^32 with no trap. The fields are rs = bits [25:21], rt = [20:16] and rd = [15:11].
- R3: An instruction with op 0 and funct 34 writes rs − rt into rd, wrapping modulo 2^32.
- R4: Op 35 (load) writes into register rt the data-memory word at effective address rs + offset, where the offset is bits [15:0].
- R5: Op 43 (store) writes register rt into data memory at effective address rs + offset. It raises the memory write strobe with that address and data, and it writes no register.
- R6: The 16-bit offset is sign-extended before it is added, so negative offsets reach lower addresses.
- R7: Register 0 always reads as zero. A write aimed at it is discarded, and the register write strobe stays low.
- R8: Bits [10:6] (the shift field) have no effect on add or subtract.
- R9: Any other op value, and op 0 with a funct other than 32 or 34, writes neither a register nor memory.
- R10: Data memory is indexed by effective-address bits [MEM_AW+1:2], so the two low address bits are ignored.
- R11: The loader writes instruction memory (ldToData = 0) or data memory (ldToData = 1) at word index ldAddr only while reset is asserted. Loader activity after reset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ldEn | input | 1 | Loader write enable, effective only in reset |
| ldToData | input | 1 | Loader target: 0 instruction memory, 1 data memory |
| ldAddr | input | MEM_AW | Loader word index |
| ldData | input | 32 | Loader word |
| dbgPc | output | 32 | Current program counter |
| dbgRegWe | output | 1 | Register write strobe this cycle |
| dbgRegAddr | output | 5 | Register write address |
| dbgRegData | output | 32 | Register write data |
| dbgMemWe | output | 1 | Data memory write strobe this cycle |
| dbgMemAddr | output | 32 | Effective byte address of the access |
| dbgMemData | output | 32 | Data memory write data |

## Verification
The bench targets sums and differences that carry across bit 31. A core that detected overflow or dropped the carry would produce the wrong wrapped value. It also uses loads with negative offsets and with offsets whose low two bits are set. A core that zero-extended the offset, or used the full byte address as an index, would fetch the wrong word. Writes to register 0, shift fields that are not zero, undefined opcodes and functs, and loader activity during the run are all mixed into a random program. Any of these would surface as a stray strobe or a changed register value in later arithmetic.

// File: rtl/core4_pkg.sv
package core4_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW = $clog2(NREG);

  localparam logic [5:0] OP_ALU = 6'd0;
  localparam logic [5:0] OP_LOADW = 6'd35;
  localparam logic [5:0] OP_STOREW = 6'd43;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;

  typedef struct packed {
    logic regWe;    // write register file
    logic memWe;    // write data memory
    logic memToReg; // register data comes from memory
    logic destRd;   // destination is rd (else rt)
    logic aluSub;   // subtract instead of add
    logic useImm;   // second operand is the sign-extended offset
  } strobe_t;
endpackage

// File: rtl/core4_ctrl.sv
module core4_ctrl
  import core4_pkg::*;
(
  input  logic [5:0] opField,
  input  logic [5:0] functField,
  output strobe_t    strobes
);
  always_comb begin
    strobes = '0;
    case (opField)
      OP_ALU: begin
        if (functField == FN_ADD || functField == FN_SUB) begin
          strobes.regWe  = 1'b1;
          strobes.destRd = 1'b1;
          strobes.aluSub = (functField == FN_SUB);
        end
      end
      OP_LOADW: begin
        strobes.regWe    = 1'b1;
        strobes.memToReg = 1'b1;
        strobes.useImm   = 1'b1;
      end
      OP_STOREW: begin
        strobes.memWe  = 1'b1;
        strobes.useImm = 1'b1;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/core4_imem.sv
module core4_imem #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldEn,
  input  logic [AW-1:0] ldAddr,
  input  logic [31:0]   ldData,
  input  logic [AW-1:0] rdIdx,
  output logic [31:0]   rdWord
);
  localparam int DEPTH = 1 << AW;
  logic [31:0] memArr [DEPTH];

  // loader writes are honoured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN && ldEn) memArr[ldAddr] <= ldData;
  end

  assign rdWord = memArr[rdIdx];
endmodule

// File: rtl/core4_regfile.sv
module core4_regfile #(
  parameter int NUM = 32,
  parameter int W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [$clog2(NUM)-1:0] rAddrA,
  input  logic [$clog2(NUM)-1:0] rAddrB,
  output logic [W-1:0]           rDataA,
  output logic [W-1:0]           rDataB,
  input  logic                   we,
  input  logic [$clog2(NUM)-1:0] wAddr,
  input  logic [W-1:0]           wData
);
  logic [W-1:0] regs [NUM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we && wAddr != '0) begin
      regs[wAddr] <= wData;
    end
  end

  assign rDataA = regs[rAddrA];
  assign rDataB = regs[rAddrB];

  // R7: entry zero never leaves its reset value
  a_r7_zero_reads: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);
endmodule

// File: rtl/core4_dpath.sv
module core4_dpath
  import core4_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [RAW-1:0]    rsIdx,
  input  logic [RAW-1:0]    rtIdx,
  input  logic [RAW-1:0]    rdIdx,
  input  logic [15:0]       immField,
  input  logic              ldEn,
  input  logic [MEM_AW-1:0] ldAddr,
  input  logic [XLEN-1:0]   ldData,
  output logic [XLEN-1:0]   pcOut,
  output logic              regWeOut,
  output logic [RAW-1:0]    regAddrOut,
  output logic [XLEN-1:0]   regDataOut,
  output logic              memWeOut,
  output logic [XLEN-1:0]   memAddrOut,
  output logic [XLEN-1:0]   memDataOut
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [XLEN-1:0] pcQ;
  logic [XLEN-1:0] rsVal, rtVal, opB, aluY, immExt, dmemRd, wData;
  logic [RAW-1:0]  wAddr;
  logic            rfWe, dmWe;
  logic [XLEN-1:0] dmemArr [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= pcQ + XLEN'(4);
  end

  core4_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .rAddrA(rsIdx),
    .rAddrB(rtIdx),
    .rDataA(rsVal),
    .rDataB(rtVal),
    .we    (rfWe),
    .wAddr (wAddr),
    .wData (wData)
  );

  assign immExt = {{(XLEN-16){immField[15]}}, immField};
  assign opB    = strobes.useImm ? immExt : rtVal;
  assign aluY   = strobes.aluSub ? (rsVal - opB) : (rsVal + opB);

  // data memory: word indexed, low two address bits dropped
  assign dmemRd = dmemArr[aluY[MEM_AW+1:2]];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (ldEn) dmemArr[ldAddr] <= ldData;
    end else if (dmWe) begin
      dmemArr[aluY[MEM_AW+1:2]] <= rtVal;
    end
  end

  assign wAddr = strobes.destRd ? rdIdx : rtIdx;
  assign wData = strobes.memToReg ? dmemRd : aluY;
  assign rfWe  = rstN && strobes.regWe && (wAddr != '0);
  assign dmWe  = rstN && strobes.memWe;

  assign pcOut      = pcQ;
  assign regWeOut   = rfWe;
  assign regAddrOut = wAddr;
  assign regDataOut = wData;
  assign memWeOut   = dmWe;
  assign memAddrOut = aluY;
  assign memDataOut = rtVal;

  // R1: program counter steps by one word per cycle
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pcQ == $past(pcQ) + XLEN'(4));
  // R5: a store never also writes a register
  a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWe |-> !rfWe);
  // R4: a load lands in rt
  a_r4_load_dest: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && strobes.memToReg) |-> wAddr == rtIdx);
endmodule

// File: rtl/core4_top.sv
module core4_top
  import core4_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic              ldToData,
  input  logic [MEM_AW-1:0] ldAddr,
  input  logic [31:0]       ldData,
  output logic [31:0]       dbgPc,
  output logic              dbgRegWe,
  output logic [4:0]        dbgRegAddr,
  output logic [31:0]       dbgRegData,
  output logic              dbgMemWe,
  output logic [31:0]       dbgMemAddr,
  output logic [31:0]       dbgMemData
);
  logic [31:0] instrWord;
  strobe_t     strobes;

  core4_imem #(.AW(MEM_AW)) u_imem (
    .clk   (clk),
    .rstN  (rstN),
    .ldEn  (ldEn && !ldToData),
    .ldAddr(ldAddr),
    .ldData(ldData),
    .rdIdx (dbgPc[MEM_AW+1:2]),
    .rdWord(instrWord)
  );

  core4_ctrl u_ctrl (
    .opField   (instrWord[31:26]),
    .functField(instrWord[5:0]),
    .strobes   (strobes)
  );

  core4_dpath #(.MEM_AW(MEM_AW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rsIdx     (instrWord[25:21]),
    .rtIdx     (instrWord[20:16]),
    .rdIdx     (instrWord[15:11]),
    .immField  (instrWord[15:0]),
    .ldEn      (ldEn && ldToData),
    .ldAddr    (ldAddr),
    .ldData    (ldData),
    .pcOut     (dbgPc),
    .regWeOut  (dbgRegWe),
    .regAddrOut(dbgRegAddr),
    .regDataOut(dbgRegData),
    .memWeOut  (dbgMemWe),
    .memAddrOut(dbgMemAddr),
    .memDataOut(dbgMemData)
  );

  // R9: undefined encodings leave all state untouched
  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(instrWord[31:26] == OP_LOADW || instrWord[31:26] == OP_STOREW ||
      (instrWord[31:26] == OP_ALU &&
       (instrWord[5:0] == FN_ADD || instrWord[5:0] == FN_SUB)))
    |-> (!dbgRegWe && !dbgMemWe));
  // R7: no strobe aimed at register zero
  a_r7_no_zero_strobe: assert property (@(posedge clk) disable iff (!rstN)
    dbgRegWe |-> dbgRegAddr != 5'd0);
endmodule

// File: tb/core4_top_tb.sv
`timescale 1ns/1ps
module core4_top_tb;
  localparam int MAW = 6;
  localparam int DEP = 1 << MAW;
  localparam int RUN_CYCLES = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldEn = 1'b0, ldToData = 1'b0;
  logic [MAW-1:0] ldAddr = '0;
  logic [31:0] ldData = '0;
  logic [31:0] dbgPc, dbgRegData, dbgMemAddr, dbgMemData;
  logic dbgRegWe, dbgMemWe;
  logic [4:0] dbgRegAddr;

  always #2.5 clk = ~clk;

  core4_top #(.MEM_AW(MAW)) u_dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldToData(ldToData),
    .ldAddr(ldAddr), .ldData(ldData), .dbgPc(dbgPc),
    .dbgRegWe(dbgRegWe), .dbgRegAddr(dbgRegAddr), .dbgRegData(dbgRegData),
    .dbgMemWe(dbgMemWe), .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  int nTests = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] prog [DEP];
  logic [31:0] dInit [DEP];
  logic [31:0] mReg [32];
  logic [31:0] mMem [DEP];
  logic [31:0] mPc;

  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic string tagOf(logic [31:0] w, int idx);
    if (idx == 20) return "R11";
    if (w[31:26] == 6'd0 && (w[5:0] == 6'd32 || w[5:0] == 6'd34)) begin
      if (w[15:11] == 5'd0) return "R7";
      if (w[10:6] != 5'd0) return "R8";
      return (w[5:0] == 6'd32) ? "R2" : "R3";
    end
    if (w[31:26] == 6'd35 || w[31:26] == 6'd43) begin
      if (w[15]) return "R6";
      if (w[1:0] != 2'd0) return "R10";
      return (w[31:26] == 6'd35) ? "R4" : "R5";
    end
    return "R9";
  endfunction

  task automatic chk(bit ok, string tag, logic [69:0] act, logic [69:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s pc=%h actual=%h expected=%h", tag, mPc, act, exp);
    end
  endtask

  // compare current debug outputs with the reference model, then commit
  task automatic stepModel();
    logic [31:0] w, rs, rt, ea, res;
    logic eWe, eMWe;
    logic [4:0] eAddr;
    logic [69:0] aR, eR, aM, eM;
    int idx;
    string tg;
    idx = int'(mPc[MAW+1:2]);
    w = prog[idx];
    tg = tagOf(w, idx);
    rs = mReg[w[25:21]];
    rt = mReg[w[20:16]];
    ea = rs + {{16{w[15]}}, w[15:0]};
    eWe = 0; eMWe = 0; eAddr = 0; res = 0;
    if (w[31:26] == 6'd0 && w[5:0] == 6'd32) begin eWe = 1; eAddr = w[15:11]; res = rs + rt; end
    else if (w[31:26] == 6'd0 && w[5:0] == 6'd34) begin eWe = 1; eAddr = w[15:11]; res = rs - rt; end
    else if (w[31:26] == 6'd35) begin eWe = 1; eAddr = w[20:16]; res = mMem[ea[MAW+1:2]]; end
    else if (w[31:26] == 6'd43) eMWe = 1;
    if (eAddr == 5'd0) eWe = 0;
    chk(dbgPc === mPc, "R1", {38'd0, dbgPc}, {38'd0, mPc});
    aR = {32'd0, dbgRegWe, dbgRegWe ? dbgRegAddr : 5'd0, dbgRegWe ? dbgRegData : 32'd0};
    eR = {32'd0, eWe, eWe ? eAddr : 5'd0, eWe ? res : 32'd0};
    chk(aR === eR, tg, aR, eR);
    aM = {5'd0, dbgMemWe, dbgMemWe ? dbgMemAddr : 32'd0, dbgMemWe ? dbgMemData : 32'd0};
    eM = {5'd0, eMWe, eMWe ? ea : 32'd0, eMWe ? rt : 32'd0};
    chk(aM === eM, tg, aM, eM);
    if (eWe) mReg[eAddr] = res;
    if (eMWe) mMem[ea[MAW+1:2]] = rt;
    mPc = mPc + 32'd4;
  endtask

  function automatic logic [31:0] randInstr();
    int k = int'($urandom % 5);
    int a = int'($urandom % 16), b = int'($urandom % 16), d = int'($urandom % 16);
    logic [31:0] j;
    case (k)
      0: return encR(a, b, d, int'($urandom % 32), 32);
      1: return encR(a, b, d, int'($urandom % 32), 34);
      2: return encI(35, a, d, int'($urandom % 65536));
      3: return encI(43, a, b, int'($urandom % 65536));
      default: begin
        j = $urandom;
        if (j[31:26] == 6'd35 || j[31:26] == 6'd43) j[31:26] = 6'd63;
        if (j[31:26] == 6'd0 && (j[5:0] == 6'd32 || j[5:0] == 6'd34)) j[5:0] = 6'd33;
        return j;
      end
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEP; i++) begin
      dInit[i] = $urandom;
      prog[i] = 32'd0;
    end
    dInit[0] = 32'h7FFF_FFFF; dInit[1] = 32'h1; dInit[2] = 32'hFFFF_FFFF; dInit[5] = 32'd32;
    prog[0]  = encI(35, 0, 1, 0);          // r1 = 7fffffff
    prog[1]  = encI(35, 0, 2, 4);          // r2 = 1
    prog[2]  = encR(1, 2, 3, 0, 32);       // R2 carry into bit 31
    prog[3]  = encI(35, 0, 4, 8);          // r4 = ffffffff
    prog[4]  = encR(4, 2, 5, 0, 32);       // R2 wrap to zero
    prog[5]  = encR(0, 2, 6, 0, 34);       // R3 0 - 1
    prog[6]  = encR(1, 2, 0, 0, 32);       // R7 write to r0 discarded
    prog[7]  = encR(0, 0, 7, 0, 32);       // R7 r0 reads zero
    prog[8]  = encR(1, 2, 8, 31, 32);      // R8 shift field ignored
    prog[9]  = encI(43, 0, 1, 12);         // R5 store to word 3
    prog[10] = encI(35, 0, 9, 15);         // R10 low bits ignored
    prog[11] = encI(35, 2, 10, 16);        // R10 base 1 + 16
    prog[12] = encI(35, 0, 12, 20);        // r12 = 32
    prog[13] = encI(35, 12, 13, -8);       // R6 negative load offset
    prog[14] = encI(43, 12, 13, -4);       // R6 negative store offset
    prog[15] = {6'd63, 26'h155_5555};      // R9 unknown op
    prog[16] = encR(1, 2, 11, 0, 33);      // R9 unknown funct
    prog[17] = encR(0, 2, 14, 5, 34);      // R3 with shift field
    prog[18] = encR(4, 4, 15, 0, 34);      // R3 x - x
    prog[19] = encI(35, 0, 16, 12);        // read back store
    prog[20] = encI(43, 0, 1, 40);         // R11 target of run-time loader
    for (int i = 21; i < DEP; i++) prog[i] = randInstr();

    // preload through the loader while reset is held
    @(negedge clk);
    for (int i = 0; i < DEP; i++) begin
      ldEn = 1; ldToData = 0; ldAddr = MAW'(i); ldData = prog[i]; @(negedge clk);
    end
    for (int i = 0; i < DEP; i++) begin
      ldEn = 1; ldToData = 1; ldAddr = MAW'(i); ldData = dInit[i]; @(negedge clk);
    end
    // R1 reset state
    chk(dbgPc === 32'd0 && !dbgRegWe && !dbgMemWe, "R1",
        {37'd0, dbgRegWe, dbgMemWe, dbgPc}, 70'd0);
    for (int i = 0; i < 32; i++) mReg[i] = 32'd0;
    for (int i = 0; i < DEP; i++) mMem[i] = dInit[i];
    mPc = 32'd0;
    // R11: loader stays busy during the run and must change nothing
    ldEn = 1; ldToData = 0; ldAddr = MAW'(20); ldData = encR(0, 0, 31, 0, 32);
    rstN = 1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      #1;
      stepModel();
      ldToData = ~ldToData;
      @(negedge clk);
    end
    ldEn = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule